// File: doc/BRIEF.md
# Sequenced-Service Watchdog Timer

This block is a watchdog timer behind a small register interface with 16-bit data. Software sets a timeout in half-second steps and then sets the enable bit. From that point the timer counts down and cannot be turned off. To keep the system alive, software must write a fixed pair of key values to the service register, in order, before the count runs out. If it does not, the block drives a one-cycle reset pulse. It then records that the most recent reset came from a timeout, and it starts counting again from the programmed period.

The half-second tick comes from a prescaler. The prescaler is sized from the input clock frequency, and a test parameter can override its length. There are two reset inputs. A power-on reset clears everything. A warm reset, which is normally driven by the timeout pulse through the system, clears everything except the timeout-cause flag. A low-power input can freeze the countdown, but only when software has set the suspend bit. That bit, like the enable bit, is protected against later changes.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset, the control word reads 0x0000, the status word reads 0x0000 and `wdog_rst_o` is low.
- R2: A control write that sets the enable bit (bit 2) loads the timeout field N (bits 15:8) into the countdown. `wdog_rst_o` then pulses exactly (N+1)·TICK clock cycles after the edge that took the write. TICK is the prescaler length in cycles, so N=0 gives one tick.
- R3: Register offsets are control 0x0, service 0x2 and status 0x4. The control word carries the timeout in bits 15:8, reset-enable in bit 3 (stored and read back), enable in bit 2 and suspend in bit 0. The status word carries the timeout cause in bit 1. Read data appears one cycle after the read strobe.
- R4: Writing 0x5555 and then 0xAAAA to the service register reloads the countdown. The next timeout then falls a full period after the 0xAAAA write.
- R5: After 0x5555, any other value cancels the sequence without a reload. A repeated 0x5555 keeps the sequence armed. A 0xAAAA that does not follow 0x5555 has no effect.
- R6: Once the enable bit is set, writing 0 to it has no effect. It reads back as 1 and the countdown keeps running.
- R7: The suspend bit takes only the value from the first control write after a reset. Later writes leave it unchanged.
- R8: Rewriting the timeout field while the timer runs does not change the current countdown. The new value applies from the next reload.
- R9: On expiry, `wdog_rst_o` is high for exactly one cycle. The status flag is set and the countdown restarts from the timeout field.
- R10: A warm reset returns the control word to 0x0000 but keeps the status flag. Only power-on reset clears the flag.
- R11: While `lowpwr_i` is high and the suspend bit is 1, the countdown and prescaler hold, so the timeout moves later by the number of held cycles. With the suspend bit at 0, `lowpwr_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high; clears all state |
| wrst | input | 1 | Warm reset, synchronous, active high; keeps the status flag |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register offset |
| wr_data | input | DATA_W | Write data |
| lowpwr_i | input | 1 | Low-power state indication |
| rd_data | output | DATA_W | Registered read data |
| wdog_rst_o | output | 1 | One-cycle timeout reset pulse |

## Verification
The bench predicts the exact cycle of every timeout pulse and compares it with the cycle in which the pulse arrives. This catches several faults:
- An off-by-one tick count, or a zero-length period mishandled at N=0, shifts the pulse by one tick.
- A service detector that ignores order, forgets to cancel on a wrong value, or drops its armed state on a repeated first key produces an early or a missing pulse.
- A timeout rewrite that applies at once, a stoppable enable, a suspend bit that can be written twice, or a freeze that ignores the suspend bit each move the pulse away from its expected cycle.
- A status flag cleared by warm reset shows up directly in a status read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [2:0]  OFS_CTRL = 3'h0;
  localparam logic [2:0]  OFS_SVC  = 3'h2;
  localparam logic [2:0]  OFS_STAT = 3'h4;
  localparam logic [15:0] KEY_ARM  = 16'h5555;
  localparam logic [15:0] KEY_FIRE = 16'hAAAA;
  localparam int BIT_SUSP = 0;
  localparam int BIT_EN   = 2;
  localparam int BIT_RSTE = 3;
  localparam int BIT_TOUT = 1;

  typedef enum logic {SVC_IDLE = 1'b0, SVC_ARMED = 1'b1} svc_state_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int TICK_CYC = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);

  logic [PW-1:0] pcnt_q;

  assign tick = run && (pcnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt_q <= '0;
    end else if (run) begin
      if (pcnt_q == LAST) pcnt_q <= '0;
      else                pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R11
  held_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(pcnt_q));
endmodule

// File: rtl/wdog_svc_detect.sv
module wdog_svc_detect
  import wdog_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              svc_wr,
  input  logic [DATA_W-1:0] svc_data,
  output logic              svc_fire
);
  svc_state_e state_q;

  assign svc_fire = svc_wr && (state_q == SVC_ARMED) && (svc_data == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SVC_IDLE;
    end else if (svc_wr) begin
      if (svc_data == KEY_ARM) state_q <= SVC_ARMED;
      else                     state_q <= SVC_IDLE;
    end
  end

  // R5
  arm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_wr && svc_data == KEY_ARM) |=> (state_q == SVC_ARMED));
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             run,
  input  logic             tick,
  output logic             expire_q
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (load) begin
        cnt_q <= load_val;
      end else if (tick) begin
        if (cnt_q == '0) begin
          expire_q <= 1'b1;
          cnt_q    <= reload_val;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R9
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    expire_q |=> !expire_q);

  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt_q));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CLK_HZ   = 32768,
  parameter int TICK_OVR = 0,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3,
  parameter int TOUT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lowpwr_i,
  output logic [DATA_W-1:0] rd_data,
  output logic              wdog_rst_o
);
  localparam int TICK_CYC = (TICK_OVR > 0) ? TICK_OVR : (CLK_HZ / 2);
  localparam int TOUT_LSB = DATA_W - TOUT_W;

  logic              soft_rst;
  logic              ctrl_wr, svc_wr;
  logic [TOUT_W-1:0] tout_q;
  logic              rste_q, en_q, susp_q, susp_lock_q, stat_q;
  logic              en_rise, svc_fire, load, freeze, run, tick, expire;
  logic [TOUT_W-1:0] load_val;
  logic [DATA_W-1:0] rd_mux;

  assign soft_rst = rst || wrst;
  assign ctrl_wr  = wr_en && (addr == ADDR_W'(OFS_CTRL));
  assign svc_wr   = wr_en && (addr == ADDR_W'(OFS_SVC));
  assign en_rise  = ctrl_wr && wr_data[BIT_EN] && !en_q;
  assign load     = en_rise || svc_fire;
  assign load_val = en_rise ? wr_data[DATA_W-1:TOUT_LSB] : tout_q;
  assign freeze   = lowpwr_i && susp_q;
  assign run      = en_q && !freeze;

  always_ff @(posedge clk) begin
    if (soft_rst) begin
      tout_q      <= '0;
      rste_q      <= 1'b0;
      en_q        <= 1'b0;
      susp_q      <= 1'b0;
      susp_lock_q <= 1'b0;
    end else if (ctrl_wr) begin
      tout_q <= wr_data[DATA_W-1:TOUT_LSB];
      rste_q <= wr_data[BIT_RSTE];
      en_q   <= en_q || wr_data[BIT_EN];
      if (!susp_lock_q) begin
        susp_q      <= wr_data[BIT_SUSP];
        susp_lock_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         stat_q <= 1'b0;
    else if (expire) stat_q <= 1'b1;
  end

  wdog_svc_detect #(.DATA_W(DATA_W)) u_svc (
    .clk(clk), .rst(soft_rst), .svc_wr(svc_wr), .svc_data(wr_data),
    .svc_fire(svc_fire)
  );

  wdog_prescaler #(.TICK_CYC(TICK_CYC)) u_presc (
    .clk(clk), .rst(soft_rst), .clr(load), .run(run), .tick(tick)
  );

  wdog_countdown #(.CNT_W(TOUT_W)) u_cnt (
    .clk(clk), .rst(soft_rst), .load(load), .load_val(load_val),
    .reload_val(tout_q), .run(run), .tick(tick), .expire_q(expire)
  );

  assign wdog_rst_o = expire;

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rd_mux[DATA_W-1:TOUT_LSB] = tout_q;
      rd_mux[BIT_RSTE]          = rste_q;
      rd_mux[BIT_EN]            = en_q;
      rd_mux[BIT_SUSP]          = susp_q;
    end else if (addr == ADDR_W'(OFS_STAT)) begin
      rd_mux[BIT_TOUT] = stat_q;
    end
  end

  always_ff @(posedge clk) begin
    if (soft_rst)   rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end

  // R6
  en_sticky_chk: assert property (@(posedge clk) disable iff (soft_rst)
    en_q |=> en_q);

  // R7
  susp_once_chk: assert property (@(posedge clk) disable iff (soft_rst)
    susp_lock_q |=> $stable(susp_q));

  // R9
  stat_set_chk: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |=> stat_q);
endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TK = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrst = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic        lowpwr_i = 1'b0;
  logic [15:0] rd_data;
  logic        wdog_rst_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer #(.TICK_OVR(TK)) i_wdog_timer (
    .clk(clk), .rst(rst), .wrst(wrst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .lowpwr_i(lowpwr_i),
    .rd_data(rd_data), .wdog_rst_o(wdog_rst_o)
  );

  // monitor: pops expected pulse cycles as pulses appear
  always @(negedge clk) begin
    if (!rst && wdog_rst_o) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R9: unexpected pulse at cycle %0d (expected none)", cyc);
      end else begin
        int e;
        e = expq.pop_front();
        if (cyc != e) begin
          bad++;
          $display("FAIL R2: pulse at cycle %0d, expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, output int e);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    e = cyc + 1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic drain(input string req, input int last);
    while (cyc < last + 1) @(negedge clk);
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL %s: %0d pulses missing, expected 0", req, expq.size());
      expq.delete();
    end
  endtask

  task automatic warm();
    @(negedge clk); wrst = 1'b1;
    @(negedge clk); wrst = 1'b0;
  endtask

  task automatic lowpwr_window(input int n);
    @(negedge clk); lowpwr_i = 1'b1;
    repeat (n) @(negedge clk);
    lowpwr_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e, e2, b;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'h0, d); chk("R1 ctrl", d, 16'h0000);
    rd(3'h4, d); chk("R1 stat", d, 16'h0000);
    chk("R1 out", wdog_rst_o, 0);

    // R2 boundary N=0
    wr(3'h0, 16'h0004, e); expq.push_back(e + TK);
    drain("R2 n0", e + TK); warm();

    // R2 and R9: N=2, two periods
    wr(3'h0, 16'h0204, e);
    expq.push_back(e + 3*TK); expq.push_back(e + 6*TK);
    drain("R9 rerun", e + 6*TK); warm();

    // R10 status survives warm reset, control cleared
    rd(3'h4, d); chk("R10 stat kept", d, 16'h0002);
    rd(3'h0, d); chk("R10 ctrl clr", d, 16'h0000);

    // R6 R8 R3: enable N=5, then try disable and rewrite field
    wr(3'h0, 16'h0504, e);
    wr(3'h0, 16'h0108, e2);
    rd(3'h0, d); chk("R6 R3 ctrl", d, 16'h010C);
    expq.push_back(e + 6*TK); expq.push_back(e + 6*TK + 2*TK);
    drain("R8 newfield", e + 8*TK); warm();

    // R4 R5 service sequence
    wr(3'h0, 16'h0504, e);
    repeat (8) @(negedge clk);
    wr(3'h2, 16'h5555, e2); wr(3'h2, 16'hAAAA, b);
    repeat (12) @(negedge clk);
    wr(3'h2, 16'h5555, e2); wr(3'h2, 16'hAAAA, b);
    expq.push_back(b + 6*TK);
    repeat (3) @(negedge clk);
    wr(3'h2, 16'h5555, e2); wr(3'h2, 16'h1234, e2);
    wr(3'h2, 16'hAAAA, e2); wr(3'h2, 16'hAAAA, e2);
    drain("R5 cancel", b + 6*TK);
    wr(3'h2, 16'h5555, e2); wr(3'h2, 16'h5555, e2); wr(3'h2, 16'hAAAA, b);
    expq.push_back(b + 6*TK);
    drain("R4 rearm", b + 6*TK); warm();

    // R7 R11 suspend freeze
    wr(3'h0, 16'h0001, e2);
    wr(3'h0, 16'h0204, e);
    expq.push_back(e + 3*TK + 10);
    rd(3'h0, d); chk("R7 susp once", d, 16'h0205);
    lowpwr_window(10);
    drain("R11 freeze", e + 3*TK + 10); warm();

    // R11 no suspend: low power ignored
    wr(3'h0, 16'h0204, e);
    expq.push_back(e + 3*TK);
    lowpwr_window(10);
    drain("R11 nosusp", e + 3*TK); warm();

    // R10 power-on reset clears status
    rd(3'h4, d); chk("R10 pre-por", d, 16'h0002);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(3'h4, d); chk("R10 por clr", d, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule